// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block drains a ring of transmit descriptors held in system memory and turns each one into a byte frame on a MAC-facing stream. Software fills descriptors, then hands them over by advancing a CPU index register. The engine walks from its own DMA index up to, but not including, that CPU index. For each descriptor it reads the buffer address, the control word and the port word, then streams the buffer byte by byte. Short frames are padded with zero bytes. When the frame is done it sets the done flag in the descriptor's control word, so software can reclaim the slot.

The register file is a flat word-addressed interface (`reg_addr`) with a combinational read. The engine has one memory master port with a single outstanding access: a request is held until `mem_ack`, and read data is valid in the acknowledge cycle. Descriptors are 16 bytes, so slot `i` lives at ring base + 16·i. Buffers may start at any byte address. Bytes are taken little-endian from the 32-bit words.

Top module: `txdma_ring`

## Requirements
- R1: After reset, DMA index, CPU index, ring base, ring count and config all read 0, `out_valid` and `mem_req` are low, and the busy flag (config bit 1) reads 0.
- R2: With transmit enabled, the engine starts a descriptor only while the DMA index (offset 3) differs from the CPU index (offset 2). When the two are equal it issues no memory access and emits no byte.
- R3: For slot i at base B (offset 0), the engine reads the buffer address from B+16i, the control word from B+16i+4 (length in bits 29:16), and the port word from B+16i+12 (port in bits 26:24). The port is shown on `out_port` for every byte of the frame.
- R4: Frame byte k is the byte at buffer address A+k, where byte j of a word sits in bits 8j+7:8j. `out_last` is high on the final byte of each frame only.
- R5: A length from 1 to 59 yields a 60-byte frame. Bytes past the length are 0x00.
- R6: A length of 0 emits no byte, yet the descriptor is still completed and the DMA index advances.
- R7: When config bit 6 is set, completion writes the fetched control word with bit 31 set back to B+16i+4, keeping length and bit 30. When bit 6 is clear, the descriptor memory is left untouched.
- R8: After a descriptor completes, the DMA index advances by one and wraps to 0 when it reaches the ring count (offset 1).
- R9: Writing a word with bit 0 set to the index-reset register (offset 4) while idle sets the DMA index to 0.
- R10: Config (offset 5) bit 0 enables transmit and bit 1 reads busy. Clearing bit 0 mid-frame lets the current descriptor finish, then busy drops and no further descriptor starts.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady.
- R12: The DMA index register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of frame |
| out_port | output | 3 | Destination port of the frame |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of bug:
- A buffer that starts mid-word and spans a word boundary: a design that refetches at the wrong moment repeats bytes or skips them.
- Short and zero lengths: a pad limit that is off by one gives 59 or 61 bytes, and a zero-length descriptor that hangs or emits a byte stalls the ring.
- A ring that wraps at the programmed count, and a run with writeback disabled: a design that gets these wrong walks off the ring or stamps done bits it should not.
- Disabling the engine while the sink stalls mid-frame: a design that drops busy early, truncates the frame, or starts the next pending descriptor is caught.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
   localparam int DATA_W = 32;

   // register word select
   localparam logic [2:0] REG_BASE  = 3'd0;
   localparam logic [2:0] REG_COUNT = 3'd1;
   localparam logic [2:0] REG_CPU   = 3'd2;
   localparam logic [2:0] REG_DMA   = 3'd3;
   localparam logic [2:0] REG_IRST  = 3'd4;
   localparam logic [2:0] REG_CFG   = 3'd5;

   // config bits
   localparam int CFG_EN   = 0;
   localparam int CFG_BUSY = 1;
   localparam int CFG_WB   = 6;

   // descriptor layout
   localparam int LEN_LSB  = 16;
   localparam int DONE_BIT = 31;
   localparam int PORT_LSB = 24;
   localparam int PORT_W   = 3;
   localparam int OFS_CTRL = 4;
   localparam int OFS_INFO = 12;

   typedef enum logic [2:0] {
      S_IDLE, S_RD_ADDR, S_RD_CTRL, S_RD_INFO,
      S_FETCH, S_SEND, S_WBACK, S_NEXT
   } txd_state_e;
endpackage

// File: rtl/txd_regs.sv
`timescale 1ns/1ps
module txd_regs
   import txd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              busy,
   input  logic              adv,
   output logic [ADDR_W-1:0] ring_base,
   output logic [IDX_W-1:0]  cpu_idx,
   output logic [IDX_W-1:0]  dma_idx,
   output logic              en,
   output logic              wb_en
);
   localparam int CNT_W = IDX_W + 1;

   logic [CNT_W-1:0] ring_cnt;
   logic [CNT_W-1:0] idx_inc;
   logic             idx_clr;

   assign idx_inc = {1'b0, dma_idx} + 1'b1;
   assign idx_clr = wr && (addr == REG_IRST) && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_base <= '0;
         ring_cnt  <= '0;
         cpu_idx   <= '0;
         dma_idx   <= '0;
         en        <= 1'b0;
         wb_en     <= 1'b0;
      end else begin
         if (wr) begin
            case (addr)
               REG_BASE:  ring_base <= ADDR_W'(wdata);
               REG_COUNT: ring_cnt  <= wdata[CNT_W-1:0];
               REG_CPU:   cpu_idx   <= wdata[IDX_W-1:0];
               REG_CFG: begin
                  en    <= wdata[CFG_EN];
                  wb_en <= wdata[CFG_WB];
               end
               default: ;
            endcase
         end
         if (idx_clr)
            dma_idx <= '0;
         else if (adv)
            dma_idx <= (idx_inc >= ring_cnt) ? '0 : idx_inc[IDX_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         REG_BASE:  rdata = DATA_W'(ring_base);
         REG_COUNT: rdata = DATA_W'(ring_cnt);
         REG_CPU:   rdata = DATA_W'(cpu_idx);
         REG_DMA:   rdata = DATA_W'(dma_idx);
         REG_CFG: begin
            rdata[CFG_EN]   = en;
            rdata[CFG_BUSY] = busy;
            rdata[CFG_WB]   = wb_en;
         end
         default: ;
      endcase
   end

   a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !idx_clr && (idx_inc >= ring_cnt)) |=> (dma_idx == '0));
   a_r9_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      idx_clr |=> (dma_idx == '0));
   a_r12_dma_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (addr == REG_DMA) && !adv) |=> $stable(dma_idx));
endmodule

// File: rtl/txd_engine.sv
`timescale 1ns/1ps
module txd_engine
   import txd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 8,
   parameter int LEN_W   = 14,
   parameter int MIN_LEN = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wb_en,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [IDX_W-1:0]  dma_idx,
   input  logic [IDX_W-1:0]  cpu_idx,
   output logic              busy,
   output logic              adv,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic [PORT_W-1:0] out_port
);
   initial assert (LEN_W >= 1 && LEN_W <= 14) else $error("LEN_W must fit bits 29:16");
   initial assert (MIN_LEN < (1 << LEN_W)) else $error("MIN_LEN exceeds LEN_W");

   txd_state_e        state;
   logic [ADDR_W-1:0] buf_ptr;
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] data_word;
   logic [LEN_W-1:0]  cnt;
   logic [LEN_W-1:0]  len_w;
   logic [LEN_W-1:0]  total;
   logic [ADDR_W-1:0] desc_addr;
   logic              final_byte;
   txd_state_e        done_state;

   assign len_w     = ctrl_word[LEN_LSB +: LEN_W];
   assign desc_addr = ring_base + ADDR_W'({dma_idx, 4'b0000});

   generate
      if (MIN_LEN > 0) begin : g_pad
         assign total = (len_w == '0) ? '0 :
                        (len_w < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : len_w;
      end else begin : g_nopad
         assign total = len_w;
      end
   endgenerate

   assign final_byte = (cnt == total - 1'b1);
   assign done_state = wb_en ? S_WBACK : S_NEXT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         buf_ptr   <= '0;
         ctrl_word <= '0;
         data_word <= '0;
         cnt       <= '0;
         out_port  <= '0;
      end else begin
         case (state)
            S_IDLE:
               if (en && (dma_idx != cpu_idx)) state <= S_RD_ADDR;
            S_RD_ADDR:
               if (mem_ack) begin
                  buf_ptr <= ADDR_W'(mem_rdata);
                  state   <= S_RD_CTRL;
               end
            S_RD_CTRL:
               if (mem_ack) begin
                  ctrl_word <= mem_rdata;
                  state     <= S_RD_INFO;
               end
            S_RD_INFO:
               if (mem_ack) begin
                  out_port <= mem_rdata[PORT_LSB +: PORT_W];
                  cnt      <= '0;
                  state    <= (len_w == '0) ? done_state : S_FETCH;
               end
            S_FETCH:
               if (mem_ack) begin
                  data_word <= mem_rdata;
                  state     <= S_SEND;
               end
            S_SEND:
               if (out_ready) begin
                  cnt     <= cnt + 1'b1;
                  buf_ptr <= buf_ptr + 1'b1;
                  if (final_byte)
                     state <= done_state;
                  else if ((buf_ptr[1:0] == 2'd3) && ((cnt + 1'b1) < len_w))
                     state <= S_FETCH;
               end
            S_WBACK:
               if (mem_ack) state <= S_NEXT;
            default:
               state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b1;
      mem_addr = '0;
      case (state)
         S_RD_ADDR: mem_addr = desc_addr;
         S_RD_CTRL: mem_addr = desc_addr + ADDR_W'(OFS_CTRL);
         S_RD_INFO: mem_addr = desc_addr + ADDR_W'(OFS_INFO);
         S_FETCH:   mem_addr = {buf_ptr[ADDR_W-1:2], 2'b00};
         S_WBACK:   mem_addr = desc_addr + ADDR_W'(OFS_CTRL);
         default:   mem_req  = 1'b0;
      endcase
   end

   assign mem_we    = (state == S_WBACK);
   assign mem_wdata = ctrl_word | (DATA_W'(1) << DONE_BIT);
   assign busy      = (state != S_IDLE);
   assign adv       = (state == S_NEXT);
   assign out_valid = (state == S_SEND);
   assign out_last  = out_valid && final_byte;
   assign out_data  = (out_valid && (cnt < len_w)) ?
                      data_word[{buf_ptr[1:0], 3'b000} +: 8] : 8'h00;

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
   a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !en) |=> !busy);
   a_r2_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(dma_idx != cpu_idx));
   a_r5_min_frame: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> ((32'(cnt) + 1) >= MIN_LEN));
   a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: rtl/txdma_ring.sv
`timescale 1ns/1ps
module txdma_ring
   import txd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 8,
   parameter int LEN_W   = 14,
   parameter int MIN_LEN = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic [2:0]        out_port
);
   initial assert (ADDR_W >= IDX_W + 4 && ADDR_W <= 32) else $error("ADDR_W out of range");

   logic              busy, adv, en, wb_en;
   logic [ADDR_W-1:0] ring_base;
   logic [IDX_W-1:0]  cpu_idx, dma_idx;

   txd_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .adv(adv),
      .ring_base(ring_base), .cpu_idx(cpu_idx), .dma_idx(dma_idx),
      .en(en), .wb_en(wb_en)
   );

   txd_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(en), .wb_en(wb_en),
      .ring_base(ring_base), .dma_idx(dma_idx), .cpu_idx(cpu_idx),
      .busy(busy), .adv(adv),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .out_port(out_port)
   );
endmodule

// File: tb/txdma_ring_tb.sv
`timescale 1ns/1ps
module txdma_ring_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        out_valid, out_ready, out_last;
   logic [7:0]  out_data;
   logic [2:0]  out_port;

   logic [31:0] mem [0:1023];
   logic        tb_wr = 1'b0;
   logic [31:0] tb_wa = '0, tb_wd = '0;
   int          ready_mode = 0;
   logic [7:0]  rx_data [0:511];
   logic        rx_last [0:511];
   logic [2:0]  rx_port [0:511];
   int          rx_n = 0;
   int          n_chk = 0, n_fail = 0;
   localparam int BASE = 32'h100;

   always #4 clk = ~clk;

   txdma_ring u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .out_port(out_port)
   );

   // memory model: one access at a time, acknowledged one cycle after request
   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (tb_wr) mem[tb_wa[11:2]] <= tb_wd;
      if (rst_n && mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[11:2]];
         if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      end
   end

   always @(negedge clk)
      case (ready_mode)
         0: out_ready <= 1'b1;
         1: out_ready <= ~out_ready;
         default: out_ready <= 1'b0;
      endcase

   always @(posedge clk)
      if (rst_n && out_valid && out_ready) begin
         rx_data[rx_n & 511] <= out_data;
         rx_last[rx_n & 511] <= out_last;
         rx_port[rx_n & 511] <= out_port;
         rx_n <= rx_n + 1;
      end

   function automatic logic [7:0] pat(int a);
      return 8'(a * 13 + 5);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic memwr(int a, logic [31:0] d);
      @(negedge clk); tb_wr = 1'b1; tb_wa = a; tb_wd = d;
      @(negedge clk); tb_wr = 1'b0;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic set_desc(int slot, int bufa, int len, int port);
      memwr(BASE + 16*slot,      bufa);
      memwr(BASE + 16*slot + 4,  (32'h1 << 30) | (len << 16));
      memwr(BASE + 16*slot + 8,  0);
      memwr(BASE + 16*slot + 12, port << 24);
   endtask

   function automatic logic [31:0] ctrl_of(int slot);
      return mem[(BASE + 16*slot + 4) >> 2];
   endfunction

   task automatic wait_done(int idx);
      logic [31:0] di, cf;
      for (int i = 0; i < 4000; i++) begin
         rd(3'd3, di); rd(3'd5, cf);
         if (di == idx && !cf[1]) break;
      end
   endtask

   task automatic check_frame(int start, int bufa, int len, int port, string req);
      int total, bad, ba, be;
      total = (len == 0) ? 0 : (len < 60 ? 60 : len);
      bad = -1; ba = 0; be = 0;
      for (int i = 0; i < total; i++) begin
         logic [7:0] e;
         e = (i < len) ? pat(bufa + i) : 8'h00;
         if (bad < 0 && (rx_data[(start+i)&511] !== e ||
             rx_last[(start+i)&511] !== (i == total-1) ||
             rx_port[(start+i)&511] !== 3'(port))) begin
            bad = i; ba = rx_data[(start+i)&511]; be = e;
         end
      end
      chk(bad < 0, req, $sformatf("frame byte %0d (data/last/port)", bad), ba, be);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk(v == 0, "R1", $sformatf("reg %0d after reset", a), v, 0);
      end
      chk(!out_valid && !mem_req, "R1", "outputs idle after reset", {out_valid, mem_req}, 0);
   endtask

   task automatic t_no_pending();
      logic [31:0] v;
      int s0 = rx_n;
      wr(3'd0, BASE); wr(3'd1, 4); wr(3'd5, 32'h41);
      repeat (20) @(negedge clk);
      rd(3'd5, v);
      chk(rx_n == s0 && !v[1], "R2", "no work while indices equal", rx_n - s0, 0);
   endtask

   task automatic t_basic();
      logic [31:0] v;
      int s0 = rx_n;
      set_desc(0, 32'h400, 64, 3);
      wr(3'd2, 1);
      wait_done(1);
      chk(rx_n - s0 == 64, "R3", "byte count for length 64", rx_n - s0, 64);
      check_frame(s0, 32'h400, 64, 3, "R4");
      v = ctrl_of(0);
      chk(v == 32'hC040_0000, "R7", "done writeback keeps fields", v, 32'hC040_0000);
      rd(3'd3, v);
      chk(v == 1, "R8", "index after one descriptor", v, 1);
   endtask

   task automatic t_pad();
      int s0 = rx_n;
      ready_mode = 1;
      set_desc(1, 32'h503, 5, 6);
      wr(3'd2, 2);
      wait_done(2);
      ready_mode = 0;
      chk(rx_n - s0 == 60, "R5", "short frame padded", rx_n - s0, 60);
      check_frame(s0, 32'h503, 5, 6, "R5");
   endtask

   task automatic t_zero();
      logic [31:0] v;
      int s0 = rx_n;
      set_desc(2, 32'h600, 0, 1);
      wr(3'd2, 3);
      wait_done(3);
      chk(rx_n == s0, "R6", "zero length emits nothing", rx_n - s0, 0);
      v = ctrl_of(2);
      chk(v[31], "R6", "zero length still done", v[31], 1);
   endtask

   task automatic t_wrap();
      logic [31:0] v;
      int s0 = rx_n;
      set_desc(3, 32'h700, 61, 5);
      set_desc(0, 32'h800, 7, 0);
      wr(3'd2, 1);
      wait_done(1);
      chk(rx_n - s0 == 121, "R8", "two frames across wrap", rx_n - s0, 121);
      check_frame(s0, 32'h700, 61, 5, "R8");
      check_frame(s0 + 61, 32'h800, 7, 0, "R8");
      rd(3'd3, v);
      chk(v == 1, "R8", "index wrapped past count", v, 1);
   endtask

   task automatic t_nowb();
      logic [31:0] v;
      int s0 = rx_n;
      wr(3'd5, 32'h01);
      set_desc(1, 32'h900, 10, 2);
      wr(3'd2, 2);
      wait_done(2);
      check_frame(s0, 32'h900, 10, 2, "R7");
      v = ctrl_of(1);
      chk(v == 32'h400A_0000, "R7", "no writeback with bit 6 clear", v, 32'h400A_0000);
   endtask

   task automatic t_disable();
      logic [31:0] v;
      logic [7:0]  d0;
      int s0 = rx_n;
      wr(3'd5, 32'h40);
      set_desc(2, 32'h980, 20, 4);
      set_desc(3, 32'h9C0, 20, 4);
      wr(3'd2, 0);
      repeat (40) @(negedge clk);
      rd(3'd3, v);
      chk(rx_n == s0 && v == 2, "R10", "disabled engine starts nothing", v, 2);
      ready_mode = 2;
      wr(3'd5, 32'h41);
      for (int i = 0; i < 100 && !out_valid; i++) @(negedge clk);
      d0 = out_data;
      repeat (3) @(negedge clk);
      chk(out_valid && out_data == d0, "R11", "byte held under stall", out_data, d0);
      wr(3'd5, 32'h40);
      rd(3'd5, v);
      chk(v[1], "R10", "busy while finishing frame", v[1], 1);
      ready_mode = 0;
      for (int i = 0; i < 400; i++) begin
         rd(3'd5, v);
         if (!v[1]) break;
      end
      repeat (40) @(negedge clk);
      rd(3'd3, v);
      chk(v == 3 && rx_n - s0 == 60, "R10", "one frame then stop (index)", v, 3);
      check_frame(s0, 32'h980, 20, 4, "R10");
      chk(!ctrl_of(3)[31] && ctrl_of(2)[31], "R10", "next descriptor untouched",
          ctrl_of(3)[31], 0);
   endtask

   task automatic t_ro_and_reset();
      logic [31:0] v;
      wr(3'd3, 0);
      rd(3'd3, v);
      chk(v == 3, "R12", "DMA index ignores writes", v, 3);
      wr(3'd4, 1);
      rd(3'd3, v);
      chk(v == 0, "R9", "index reset clears DMA index", v, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
   end

   initial begin
      for (int w = 0; w < 1024; w++)
         memwr(4*w, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_no_pending();
      t_basic();
      t_pad();
      t_zero();
      t_wrap();
      t_nowb();
      t_disable();
      t_ro_and_reset();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule